// File: doc/BRIEF.md
# Frequency Acquisition Sweep Controller

This block steers an oscillator's control code so that a phase-locked loop can find the incoming data rate. Starting from the bottom of a band set around the centre frequency, it ramps the code upward to the top of the band. It then ramps back down to the bottom and waits one slow system-clock period. After that it begins the next triangle. The cycle repeats until the loop reports lock. The code is meant to feed a DAC that sets the oscillator control voltage.

Once lock is reported, the code is frozen and the loop owns the frequency. If the loop loses lock while data is still arriving, the sweep resumes upward from the frozen code. If the incoming data disappears, the controller holds both its code and its place in the sequence. When data returns, it picks up where it stopped, so a switch between two sources at the same rate relocks without a new sweep. Dwell timing uses a one-cycle strobe from a slow system clock that is independent of the data rate.

Top module: `fsweep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `ctrl_code` becomes `CODE_LO` and `mode` becomes 0 (idle).
- R2: In idle with `data_present` low, `mode` and `ctrl_code` remain unchanged; with `data_present` high, the next edge moves `mode` to 1 (sweep up) with the code unchanged.
- R3: In sweep up (`mode`=1), with data present and no lock, each edge raises `ctrl_code` by `STEP`, saturating at `CODE_HI`; `ctrl_code` never leaves [`CODE_LO`, `CODE_HI`].
- R4: The edge on which an upward step reaches or would pass `CODE_HI` sets the code to `CODE_HI` and `mode` to 2 (sweep down).
- R5: In sweep down, each edge lowers the code by `STEP`. The edge on which the code reaches or would pass `CODE_LO` sets the code to `CODE_LO` and `mode` to 3 (dwell).
- R6: In dwell, the code is held and `mode` stays 3 until an edge where `sys_tick` is high, which moves `mode` to 1; the triangle then repeats without limit.
- R7: `pll_lock` high at an edge in sweep up, sweep down or dwell moves `mode` to 4 (locked) and leaves the code unchanged on that edge.
- R8: In locked with data present and `pll_lock` high, `ctrl_code` and `mode` stay unchanged.
- R9: `data_present` low at an edge in any mode other than idle moves `mode` to 5 (hold). While in hold with data absent, code and mode stay unchanged regardless of `pll_lock`.
- R10: When data returns in hold, the next edge restores the mode that was active when data was lost, with the code unchanged.
- R11: In locked, `pll_lock` low with data present moves `mode` to 1 with the code unchanged, and sweeping continues upward from that code.
- R12: Data loss takes priority over lock: `data_present` low and `pll_lock` high on the same edge in sweep up lead to hold, and the restored mode after data returns is sweep up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | One-cycle strobe, once per slow system-clock period |
| data_present | input | 1 | High while input data transitions are detected |
| pll_lock | input | 1 | High while the loop reports phase lock |
| ctrl_code | output | CODE_W | Oscillator control code for the DAC |
| mode | output | 3 | 0 idle, 1 sweep up, 2 sweep down, 3 dwell, 4 locked, 5 hold |

## Verification
Two events can fall on the same edge: lock being reported and data disappearing. Either of them can also coincide with a sweep step. The bench raises `pll_lock` and drops `data_present` together while the code is ramping. It then expects hold with the code unstepped and, once data is back, a return to sweep up rather than locked. A separate edge with lock alone during the ramp must freeze the code at its pre-edge value, which is the evidence that lock overrides the step.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UP     = 3'd1,
        ST_DOWN   = 3'd2,
        ST_DWELL  = 3'd3,
        ST_LOCKED = 3'd4,
        ST_HOLD   = 3'd5
    } sweep_state_e;

    typedef enum logic [1:0] {
        CMD_KEEP = 2'd0,
        CMD_INC  = 2'd1,
        CMD_DEC  = 2'd2
    } code_cmd_e;

    // true for the modes in which the code ramps
    function automatic logic is_ramping(input sweep_state_e s);
        return (s == ST_UP) || (s == ST_DOWN);
    endfunction

endpackage

// File: rtl/fsweep_code.sv
module fsweep_code
    import fsweep_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int CODE_LO = 26,
    parameter int CODE_HI = 230,
    parameter int STEP    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  code_cmd_e         cmd,
    output logic [CODE_W-1:0] code,
    output logic              near_hi,
    output logic              near_lo
);
    localparam int SUM_W = CODE_W + 1;
    localparam logic [SUM_W-1:0] LO_W   = SUM_W'(CODE_LO);
    localparam logic [SUM_W-1:0] HI_W   = SUM_W'(CODE_HI);
    localparam logic [SUM_W-1:0] STEP_W = SUM_W'(STEP);

    logic [SUM_W-1:0] up_sum;

    always_comb begin
        up_sum  = {1'b0, code} + STEP_W;
        near_hi = (up_sum >= HI_W);
        near_lo = ({1'b0, code} <= (LO_W + STEP_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CODE_W'(CODE_LO);
        end else begin
            case (cmd)
                CMD_INC: code <= near_hi ? CODE_W'(CODE_HI) : up_sum[CODE_W-1:0];
                CMD_DEC: code <= near_lo ? CODE_W'(CODE_LO) : (code - CODE_W'(STEP));
                default: code <= code;
            endcase
        end
    end
endmodule

// File: rtl/fsweep_fsm.sv
module fsweep_fsm
    import fsweep_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sys_tick,
    input  logic         data_present,
    input  logic         pll_lock,
    input  logic         near_hi,
    input  logic         near_lo,
    output sweep_state_e state,
    output code_cmd_e    cmd
);
    sweep_state_e nxt;
    sweep_state_e resume;

    always_comb begin
        nxt = state;
        cmd = CMD_KEEP;
        if (state != ST_IDLE && state != ST_HOLD && !data_present) begin
            nxt = ST_HOLD;
        end else begin
            case (state)
                ST_IDLE:   if (data_present) nxt = ST_UP;
                ST_UP: begin
                    if (pll_lock) nxt = ST_LOCKED;
                    else begin
                        cmd = CMD_INC;
                        if (near_hi) nxt = ST_DOWN;
                    end
                end
                ST_DOWN: begin
                    if (pll_lock) nxt = ST_LOCKED;
                    else begin
                        cmd = CMD_DEC;
                        if (near_lo) nxt = ST_DWELL;
                    end
                end
                ST_DWELL: begin
                    if (pll_lock)      nxt = ST_LOCKED;
                    else if (sys_tick) nxt = ST_UP;
                end
                ST_LOCKED: if (!pll_lock) nxt = ST_UP;
                ST_HOLD:   if (data_present) nxt = resume;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            resume <= ST_IDLE;
        end else begin
            state <= nxt;
            if (nxt == ST_HOLD && state != ST_HOLD) resume <= state;
        end
    end
endmodule

// File: rtl/fsweep_ctrl.sv
module fsweep_ctrl
    import fsweep_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int CODE_LO = 26,
    parameter int CODE_HI = 230,
    parameter int STEP    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_tick,
    input  logic              data_present,
    input  logic              pll_lock,
    output logic [CODE_W-1:0] ctrl_code,
    output logic [2:0]        mode
);
    sweep_state_e st;
    code_cmd_e    cmd;
    logic         near_hi;
    logic         near_lo;

    fsweep_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sys_tick     (sys_tick),
        .data_present (data_present),
        .pll_lock     (pll_lock),
        .near_hi      (near_hi),
        .near_lo      (near_lo),
        .state        (st),
        .cmd          (cmd)
    );

    fsweep_code #(
        .CODE_W  (CODE_W),
        .CODE_LO (CODE_LO),
        .CODE_HI (CODE_HI),
        .STEP    (STEP)
    ) u_code (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .code    (ctrl_code),
        .near_hi (near_hi),
        .near_lo (near_lo)
    );

    assign mode = st;
endmodule

// File: rtl/fsweep_chk.sv
module fsweep_chk #(
    parameter int CODE_W  = 8,
    parameter int CODE_LO = 26,
    parameter int CODE_HI = 230,
    parameter int STEP    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sys_tick,
    input logic              data_present,
    input logic              pll_lock,
    input logic [CODE_W-1:0] ctrl_code,
    input logic [2:0]        mode
);
    logic [CODE_W:0] stepped_up;
    assign stepped_up = {1'b0, ctrl_code} + (CODE_W + 1)'(STEP);

    AST_CODE_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (ctrl_code >= CODE_W'(CODE_LO)) && (ctrl_code <= CODE_W'(CODE_HI))); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && data_present && !pll_lock && stepped_up < (CODE_W + 1)'(CODE_HI))
        |=> (ctrl_code == $past(stepped_up[CODE_W-1:0]))); // R3

    AST_FROZEN_CODE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 || mode == 3'd5 || mode == 3'd3) |=> $stable(ctrl_code)); // R8

    AST_LOSS_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!data_present && mode != 3'd0) |=> (mode == 3'd5)); // R9

    AST_DWELL_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && data_present && !pll_lock && !sys_tick) |=> (mode == 3'd3)); // R6

    AST_LOCK_CATCH: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && data_present && pll_lock) |=> (mode == 3'd4)); // R7
endmodule

bind fsweep_ctrl fsweep_chk #(
    .CODE_W  (CODE_W),
    .CODE_LO (CODE_LO),
    .CODE_HI (CODE_HI),
    .STEP    (STEP)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sys_tick     (sys_tick),
    .data_present (data_present),
    .pll_lock     (pll_lock),
    .ctrl_code    (ctrl_code),
    .mode         (mode)
);

// File: tb/fsweep_ctrl_test.sv
`timescale 1ns/1ps
module fsweep_ctrl_test;
    localparam int W  = 8;
    localparam int LO = 26;
    localparam int HI = 230;
    localparam int ST = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sys_tick = 1'b0;
    logic         data_present = 1'b0;
    logic         pll_lock = 1'b0;
    logic [W-1:0] ctrl_code;
    logic [2:0]   mode;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    fsweep_ctrl #(.CODE_W(W), .CODE_LO(LO), .CODE_HI(HI), .STEP(ST)) uut (
        .clk(clk), .rst(rst), .sys_tick(sys_tick), .data_present(data_present),
        .pll_lock(pll_lock), .ctrl_code(ctrl_code), .mode(mode)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int exp_mode, input int exp_code);
        total = total + 1;
        if (mode !== 3'(exp_mode) || ctrl_code !== W'(exp_code)) begin
            bad = bad + 1;
            $display("FAIL %s: mode=%0d code=%0d expected mode=%0d code=%0d",
                     req, mode, ctrl_code, exp_mode, exp_code);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; data_present = 1'b0; pll_lock = 1'b0; sys_tick = 1'b0;
        tick(3);
        check("R1 reset", 0, LO);
        rst = 1'b0;
    endtask

    task automatic t_idle();
        tick(5);
        check("R2 idle without data", 0, LO);
        data_present = 1'b1;
        tick(1);
        check("R2 data starts sweep", 1, LO);
    endtask

    task automatic t_ramp();
        tick(10);
        check("R3 upward steps", 1, LO + 10 * ST);
        tick(40);
        check("R3 just below top", 1, LO + 50 * ST);
        tick(1);
        check("R4 top turns down", 2, HI);
        tick(50);
        check("R5 downward steps", 2, LO + ST);
        tick(1);
        check("R5 bottom enters dwell", 3, LO);
    endtask

    task automatic t_dwell();
        tick(7);
        check("R6 dwell waits for tick", 3, LO);
        sys_tick = 1'b1;
        tick(1);
        sys_tick = 1'b0;
        check("R6 tick restarts sweep", 1, LO);
        tick(3);
        check("R6 second triangle climbs", 1, LO + 3 * ST);
    endtask

    task automatic t_lock_and_loss();
        pll_lock = 1'b1;
        tick(1);
        check("R7 lock freezes code", 4, LO + 3 * ST);
        tick(5);
        check("R8 locked holds", 4, LO + 3 * ST);
        data_present = 1'b0;
        tick(1);
        check("R9 data loss enters hold", 5, LO + 3 * ST);
        pll_lock = 1'b0;
        tick(3);
        check("R9 hold ignores lock", 5, LO + 3 * ST);
        pll_lock = 1'b1;
        tick(2);
        check("R9 hold ignores lock high", 5, LO + 3 * ST);
        data_present = 1'b1;
        tick(1);
        check("R10 resume locked", 4, LO + 3 * ST);
        pll_lock = 1'b0;
        tick(1);
        check("R11 lock lost resumes up", 1, LO + 3 * ST);
        tick(1);
        check("R11 sweep continues", 1, LO + 4 * ST);
    endtask

    task automatic t_collision();
        data_present = 1'b0;
        pll_lock = 1'b1;
        tick(1);
        check("R12 loss beats lock", 5, LO + 4 * ST);
        tick(2);
        check("R12 hold steady", 5, LO + 4 * ST);
        data_present = 1'b1;
        pll_lock = 1'b0;
        tick(1);
        check("R12 resume sweep up", 1, LO + 4 * ST);
        tick(1);
        check("R12 step after resume", 1, LO + 5 * ST);
    endtask

    task automatic t_dwell_loss();
        // ramp to top and back into dwell, then lose data there
        tick(46);
        check("R4 second top", 2, HI);
        tick(51);
        check("R5 second dwell", 3, LO);
        data_present = 1'b0;
        tick(1);
        check("R9 loss in dwell", 5, LO);
        data_present = 1'b1;
        tick(1);
        check("R10 resume dwell", 3, LO);
        pll_lock = 1'b1;
        tick(1);
        check("R7 lock from dwell", 4, LO);
        pll_lock = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_ramp();
        t_dwell();
        t_lock_and_loss();
        t_collision();
        t_dwell_loss();
        rst = 1'b1;
        tick(1);
        check("R1 reset from locked run", 0, LO);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule